// File: doc/BRIEF.md
# Accelerator Control and Status Register Slave

This block is the register front end of a compute accelerator. Software reaches it over a 32-bit AXI-lite slave port. It launches the kernel through a start handshake and keeps a sticky record of kernel completion. It can re-launch the kernel by itself each time the kernel reports that it can take new work. It also reduces two interrupt sources, done and ready, to one interrupt line. Each source has its own enable and a status bit, and one master enable sits above both.

The kernel handshake is simple. The start output stays high until the kernel pulses ready. The kernel reports completion with a single-cycle done pulse. It also drives idle and ready levels, and software reads these back as they are. The block also holds two 32-bit read-only identifiers, set as parameters: a type word and a version word. It also passes a 64-bit interrupt source address from an input to two read-only words.

Top module: `kern_ctl_axil`

## Requirements
- R1: After reset the following are all zero: the start flag, the done flag, auto-restart, the master enable, the source enables and the source status bits. `kern_start` and `irq` are low, and no write or read response is pending.
- R2: A write's address and data may be accepted in either order. The write takes effect, and `bvalid` rises, on the clock edge after the later of the two is accepted. A read returns data with `rvalid` one cycle after its address is accepted. Every response is OKAY (`bresp` and `rresp` equal 0).
- R3: At control offset 0x00, writing 1 to bit 0 raises `kern_start`, and writing 0 to it has no effect. Start stays high until the kernel asserts `kern_ready` or software reads the control word. Read bit 0 shows the start flag.
- R4: A `kern_done` pulse sets control bit 1. The bit holds until the next read of the control word, which returns 1 and then clears it. A done pulse in the same cycle as that read wins. Control bit 2 reads `kern_idle` and bit 3 reads `kern_ready` live.
- R5: Control bit 7 is a read/write auto-restart enable. While it is set, `kern_ready` leaves `kern_start` high on the next cycle instead of clearing it.
- R6: Offset 0x04 bit 0 is the master interrupt enable. At offset 0x08, bit 0 enables the done source and bit 1 enables the ready source. At offset 0x0C, bit 0 is the done status and bit 1 is the ready status. A status bit sets on its event only while its source is enabled, and writing 1 to a status bit toggles it.
- R7: `irq` is high exactly when the master enable is set and at least one source has both its enable and its status bit set.
- R8: Offset 0x10 reads `TYPE_ID` and offset 0x14 reads `VERSION_ID`. Offsets 0x18 and 0x1C read the low and high halves of `isr_addr`. Writes to these four offsets change nothing.
- R9: Reads of any other offset return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| isr_addr | input | 64 | Interrupt source address, shown read-only |
| kern_start | output | 1 | Start request to the kernel |
| kern_done | input | 1 | Kernel completion pulse |
| kern_idle | input | 1 | Kernel idle level |
| kern_ready | input | 1 | Kernel can accept a new start |
| irq | output | 1 | Combined interrupt |

## Verification
The bench keeps the default ADDR_W of 6. The address space is therefore 0x00 to 0x3C, and the eight offsets from 0x20 up are unmapped, so the read-as-zero and write-ignored behaviour can be exercised. TYPE_ID and VERSION_ID are overridden with distinct non-zero patterns, so that a swapped or dropped identifier shows up. The isr_addr input carries a different value in each half, so a read of the wrong half is seen.

// File: rtl/kern_ctl_axil.sv
module kern_ctl_axil #(
  parameter int          ADDR_W     = 6,
  parameter logic [31:0] TYPE_ID    = 32'h0000_0001,
  parameter logic [31:0] VERSION_ID = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [63:0]       isr_addr,
  output logic              kern_start,
  input  logic              kern_done,
  input  logic              kern_idle,
  input  logic              kern_ready,
  output logic              irq
);
  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] IX_CTRL = WI_W'(0);
  localparam logic [WI_W-1:0] IX_GIE  = WI_W'(1);
  localparam logic [WI_W-1:0] IX_IER  = WI_W'(2);
  localparam logic [WI_W-1:0] IX_ISR  = WI_W'(3);
  localparam logic [WI_W-1:0] IX_TYPE = WI_W'(4);
  localparam logic [WI_W-1:0] IX_VER  = WI_W'(5);
  localparam logic [WI_W-1:0] IX_ADLO = WI_W'(6);
  localparam logic [WI_W-1:0] IX_ADHI = WI_W'(7);

  logic              aw_have, w_have;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [7:0]        w_byte_q;
  logic              start_q, done_q, auto_q, gie_q;
  logic [1:0]        ier_q, isr_q;
  logic [31:0]       rd_mux;

  logic [WI_W-1:0] wr_idx, rd_idx;
  logic            wr_go, rd_go, rd_ctrl;
  logic            wr_ctrl, wr_gie, wr_ier, wr_isr;
  logic            unused_bits;

  assign wr_idx  = aw_addr_q[ADDR_W-1:2];
  assign rd_idx  = araddr[ADDR_W-1:2];
  assign awready = ~aw_have;
  assign wready  = ~w_have;
  assign arready = ~rvalid;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;
  assign wr_go   = aw_have & w_have & ~bvalid;
  assign rd_go   = arvalid & arready;
  assign rd_ctrl = rd_go & (rd_idx == IX_CTRL);
  assign wr_ctrl = wr_go & (wr_idx == IX_CTRL);
  assign wr_gie  = wr_go & (wr_idx == IX_GIE);
  assign wr_ier  = wr_go & (wr_idx == IX_IER);
  assign wr_isr  = wr_go & (wr_idx == IX_ISR);
  assign kern_start = start_q;
  assign irq     = gie_q & |(ier_q & isr_q);
  assign unused_bits = ^{wdata[31:8], aw_addr_q[1:0], araddr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_have   <= 1'b0;
      w_have    <= 1'b0;
      aw_addr_q <= '0;
      w_byte_q  <= '0;
      bvalid    <= 1'b0;
    end else begin
      if (awvalid && awready) begin
        aw_have   <= 1'b1;
        aw_addr_q <= awaddr;
      end
      if (wvalid && wready) begin
        w_have   <= 1'b1;
        w_byte_q <= wdata[7:0];
      end
      if (wr_go) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= 2'b00;
      isr_q   <= 2'b00;
    end else begin
      start_q <= (wr_ctrl & w_byte_q[0]) | (auto_q & kern_ready) |
                 (start_q & ~kern_ready & ~rd_ctrl);
      done_q  <= kern_done | (done_q & ~rd_ctrl);
      if (wr_ctrl) auto_q <= w_byte_q[7];
      if (wr_gie)  gie_q  <= w_byte_q[0];
      if (wr_ier)  ier_q  <= w_byte_q[1:0];
      isr_q <= (isr_q ^ (wr_isr ? w_byte_q[1:0] : 2'b00)) |
               ({kern_ready, kern_done} & ier_q);
    end
  end

  always_comb begin
    unique case (rd_idx)
      IX_CTRL: rd_mux = {24'd0, auto_q, 3'd0, kern_ready, kern_idle, done_q, start_q};
      IX_GIE:  rd_mux = {31'd0, gie_q};
      IX_IER:  rd_mux = {30'd0, ier_q};
      IX_ISR:  rd_mux = {30'd0, isr_q};
      IX_TYPE: rd_mux = TYPE_ID;
      IX_VER:  rd_mux = VERSION_ID;
      IX_ADLO: rd_mux = isr_addr[31:0];
      IX_ADHI: rd_mux = isr_addr[63:32];
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_go) begin
      rvalid <= 1'b1;
      rdata  <= rd_mux;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

module kern_ctl_axil_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bvalid,
  input logic              bready,
  input logic              rvalid,
  input logic              rready,
  input logic [31:0]       rdata,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic              kern_start,
  input logic              kern_ready,
  input logic              kern_done,
  input logic              auto_q,
  input logic              done_q,
  input logic [1:0]        ier_q,
  input logic [1:0]        isr_q,
  input logic              wr_go
);
  logic ctrl_rd;
  assign ctrl_rd = arvalid & arready & (araddr[ADDR_W-1:2] == '0);

  // R2
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R3
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kern_start && !kern_ready && !ctrl_rd |=> kern_start);
  // R3
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kern_start && kern_ready && !auto_q && !wr_go |=> !kern_start);
  // R4
  done_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kern_done |=> done_q);
  // R5
  auto_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q && kern_ready |=> kern_start);
  // R6
  isr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_q[0] && !ier_q[0] && !wr_go |=> !isr_q[0]);
endmodule

bind kern_ctl_axil kern_ctl_axil_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_kern_ctl_axil.sv
module test_kern_ctl_axil;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam logic [31:0] T_ID = 32'hA5C3_0E71;
  localparam logic [31:0] V_ID = 32'h0203_0419;
  localparam logic [63:0] SRC_AD = 64'h1234_5678_9ABC_DEF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic bready = 1'b1, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic kern_done = 1'b0, kern_idle = 1'b0, kern_ready = 1'b0;
  logic awready, wready, bvalid, arready, rvalid, kern_start, irq;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0;

  kern_ctl_axil #(.ADDR_W(AW), .TYPE_ID(T_ID), .VERSION_ID(V_ID)) i_kern_ctl_axil (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready), .bresp(bresp), .bvalid(bvalid),
    .bready(bready), .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .isr_addr(SRC_AD), .kern_start(kern_start), .kern_done(kern_done),
    .kern_idle(kern_idle), .kern_ready(kern_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  bit m_start, m_done, m_auto, m_gie, m_awh, m_wh;
  bit [1:0] m_ier, m_isr;
  logic [AW-1:0] m_aaddr;
  logic [31:0] m_wdat;
  logic [31:0] exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] m_read(input int idx);
    case (idx)
      0: return {24'd0, m_auto, 3'd0, kern_ready, kern_idle, m_done, m_start};
      1: return {31'd0, m_gie};
      2: return {30'd0, m_ier};
      3: return {30'd0, m_isr};
      4: return T_ID;
      5: return V_ID;
      6: return SRC_AD[31:0];
      7: return SRC_AD[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(input int idx);
    case (idx)
      0: return "R4 ctrl";
      1, 2, 3: return "R6 irq regs";
      4, 5, 6, 7: return "R8 id";
      default: return "R9 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_done = 0; m_auto = 0; m_gie = 0; m_ier = 0; m_isr = 0;
      m_awh = 0; m_wh = 0;
    end else begin
      bit go, rdc, n_start, n_done;
      bit [1:0] tog, n_isr;
      int widx, ridx;
      go = m_awh && m_wh;
      widx = int'(m_aaddr[AW-1:2]);
      ridx = int'(araddr[AW-1:2]);
      rdc = arvalid && arready && ridx == 0;
      if (arvalid && arready) begin
        exp_q.push_back(m_read(ridx));
        tag_q.push_back(rtag(ridx));
      end
      n_start = (go && widx == 0 && m_wdat[0]) || (m_auto && kern_ready) ||
                (m_start && !kern_ready && !rdc);
      n_done = kern_done || (m_done && !rdc);
      tog = (go && widx == 3) ? m_wdat[1:0] : 2'b00;
      n_isr = (m_isr ^ tog) | ({kern_ready, kern_done} & m_ier);
      if (go && widx == 0) m_auto = m_wdat[7];
      if (go && widx == 1) m_gie = m_wdat[0];
      if (go && widx == 2) m_ier = m_wdat[1:0];
      m_start = n_start; m_done = n_done; m_isr = n_isr;
      if (go) begin m_awh = 0; m_wh = 0; end
      if (awvalid && awready) begin m_awh = 1; m_aaddr = awaddr; end
      if (wvalid && wready) begin m_wh = 1; m_wdat = wdata; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 R5 kern_start", {31'd0, kern_start}, {31'd0, m_start});
      check("R7 irq", {31'd0, irq}, {31'd0, m_gie && |(m_ier & m_isr)});
      if (bvalid) check("R2 bresp", {30'd0, bresp}, 32'd0);
      if (rvalid) begin
        check("R2 rresp", {30'd0, rresp}, 32'd0);
        if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'd1, 32'd0);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic send_aw(input logic [AW-1:0] a);
    awaddr = a; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d);
    wdata = d; wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 1'b0;
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int order);
    @(negedge clk);
    if (order == 0) fork send_aw(a); send_w(d); join
    else if (order == 1) begin send_aw(a); repeat (2) @(negedge clk); send_w(d); end
    else begin send_w(d); repeat (2) @(negedge clk); send_aw(a); end
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); kern_done = 1'b1; @(negedge clk); kern_done = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); kern_ready = 1'b1; @(negedge clk); kern_ready = 1'b0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    check("R1 kern_start", {31'd0, kern_start}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 bvalid", {31'd0, bvalid}, 32'd0);
    check("R1 rvalid", {31'd0, rvalid}, 32'd0);
    for (int i = 0; i < 16; i++) rd(AW'(i * 4));
    // R3 start and kernel ready
    wr(6'h00, 32'h1, 0);
    repeat (3) @(negedge clk);
    pulse_ready();
    wr(6'h00, 32'h1, 1);
    rd(6'h00);
    wr(6'h00, 32'h0, 2);
    // R4 done sticky, clear on read, live idle and ready
    pulse_done();
    kern_idle = 1'b1;
    rd(6'h00);
    rd(6'h00);
    @(negedge clk); kern_ready = 1'b1;
    rd(6'h00);
    kern_ready = 1'b0; kern_idle = 1'b0;
    // R5 auto restart
    wr(6'h00, 32'h81, 2);
    pulse_ready();
    repeat (2) @(negedge clk);
    pulse_ready();
    rd(6'h00);
    wr(6'h00, 32'h00, 0);
    pulse_ready();
    rd(6'h00);
    // R6 R7 interrupts
    pulse_done();
    rd(6'h0C);
    wr(6'h08, 32'h3, 0);
    wr(6'h04, 32'h1, 1);
    pulse_done();
    rd(6'h0C);
    wr(6'h0C, 32'h1, 0);
    rd(6'h0C);
    wr(6'h0C, 32'h2, 2);
    rd(6'h0C);
    pulse_ready();
    wr(6'h04, 32'h0, 0);
    wr(6'h04, 32'h1, 0);
    wr(6'h08, 32'h0, 1);
    wr(6'h0C, 32'h3, 0);
    pulse_ready();
    pulse_done();
    rd(6'h0C);
    rd(6'h08);
    rd(6'h04);
    // R8 R9 ignored writes
    wr(6'h10, 32'hFFFF_FFFF, 0);
    wr(6'h18, 32'h0, 1);
    wr(6'h24, 32'hFFFF_FFFF, 2);
    for (int i = 0; i < 16; i++) rd(AW'(i * 4));
    repeat (5) @(negedge clk);
    check("R2 all reads answered", exp_q.size(), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule